// File: doc/BRIEF.md
# Display Gamma Table Write Port

This block holds the two colour-correction tables that a display pipe uses. The first is a direct table of 256 entries with a 10-bit value for each of red, green and blue. The second is a piecewise-linear table of 128 entries with a 16-bit base and a 16-bit delta per colour channel. Software reaches both tables through a small set of registers on a simple write strobe: a select code, a 32-bit data word and an enable. It writes an entry pointer, then streams colour data. The block steps the pointer by itself.

Two of the streaming registers send one colour channel per write. A three-state machine tracks which channel comes next. COMP_RED moves to COMP_GREEN and COMP_GREEN moves to COMP_BLUE on each accepted sequential or piecewise-linear write. COMP_BLUE wraps back to COMP_RED on the next such write, and that wrap also advances the entry pointer. A pointer write or a packed-colour write sends the machine straight back to COMP_RED, whatever its state.

A per-channel enable mask decides which channels are actually stored. Its bit order runs blue, green, red, which is the reverse of the streaming order. A mode bit chooses which table the streaming registers reach. A read port shows any entry to the display side, or to a test environment. A one-cycle pulse reports that the table contents changed.

Top module: `gamma_lut_port`

## Requirements
- R1: After reset, direct-table entry i holds i*1023/255 (integer division) in each channel. `ramp_rd_data` packs blue in bits 9:0, green in bits 19:10 and red in bits 29:20.
- R2: After reset, piecewise entry i holds, in every channel, a base of (i*65535/127) with bits 5:0 cleared. Its delta is 0x200, except entry 127, whose delta is 0.
- R3: A write with select 0 loads the entry pointer from data bits 7:0 and returns the channel state to red (`cur_comp`=0). After reset the pointer is 0, the channel state is 0, the mode is 0 and the mask is 3'b111.
- R4: A write with select 1 (sequential colour) in mode 0 writes channel c of the pointed entry, where c is red, green and blue for `cur_comp` 0, 1 and 2. The stored value is data bits 15:6. It is stored only if mask bit (2-c) is set, because mask bit 0 is blue, bit 1 is green and bit 2 is red.
- R5: Every accepted sequential write advances `cur_comp`. After blue it returns to 0 and the pointer increments, wrapping 255 to 0.
- R6: A write with select 3 (piecewise data) in mode 1 writes channel `cur_comp` of piecewise entry pointer[6:0], under the same mask rule as R4. The base is data[15:0] and the delta is data[31:16], each stored with bits 5:0 forced to zero.
- R7: After the third piecewise write, `cur_comp` returns to 0. Pointer bits 6:0 increment modulo 128 while pointer bit 7 keeps its value.
- R8: A write with select 2 (packed colour) in mode 0 stores blue from data[9:0], green from data[19:10] and red from data[29:20], each under its mask bit. It then always increments the pointer (255 wraps to 0) and returns `cur_comp` to 0.
- R9: Select 4 loads the mode from data bit 0. In mode 1, sequential and packed writes are ignored. In mode 0, piecewise writes are ignored. An ignored write leaves the tables, the pointer and `cur_comp` unchanged.
- R10: `table_changed` is high for exactly the cycle after a write that stored at least one channel, and low otherwise.
- R11: Select 5 loads the channel mask from data bits 2:0. Selects 6 and 7 have no effect on any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code |
| wr_data | input | 32 | Write data |
| ramp_rd_addr | input | 8 | Direct-table read entry |
| ramp_rd_data | output | 30 | Direct-table entry {red, green, blue} |
| pwl_rd_entry | input | 7 | Piecewise-table read entry |
| pwl_rd_comp | input | 2 | Piecewise read channel (0 red, 1 green, 2 blue) |
| pwl_rd_base | output | 16 | Piecewise base of the selected channel |
| pwl_rd_delta | output | 16 | Piecewise delta of the selected channel |
| cur_index | output | 8 | Current entry pointer |
| cur_comp | output | 2 | Current channel state |
| cur_mode | output | 1 | Current table mode |
| table_changed | output | 1 | Pulse after a write that stored data |

## Verification
The assertions assume that `wr_sel` and `wr_data` hold known values whenever `wr_en` is high. They also assume that each write is a single-cycle strobe sampled at the rising edge, so that one cycle after the strobe the pointer and channel state reflect exactly that write. The stimulus changes inputs only at falling edges and always drives known values. It draws select codes over the full 3-bit range, including the unused codes, and switches mode and mask often, so that writes in the wrong mode, partially masked writes and pointer wraps at 255 and at bit 7 all occur.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
    localparam int CH_W = 10;
    localparam int PWL_FW = 16;
    localparam int PWL_LZ = 6;

    typedef enum logic [2:0] {
        SEL_INDEX  = 3'd0,
        SEL_SEQ    = 3'd1,
        SEL_PACKED = 3'd2,
        SEL_PWL    = 3'd3,
        SEL_MODE   = 3'd4,
        SEL_MASK   = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        COMP_RED   = 2'd0,
        COMP_GREEN = 2'd1,
        COMP_BLUE  = 2'd2
    } comp_e;
endpackage

// File: rtl/gamma_comp_fsm.sv
module gamma_comp_fsm
    import gamma_lut_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step,
    input  logic  clear,
    output comp_e comp,
    output logic  wrap
);
    comp_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= COMP_RED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = COMP_RED;
        end else if (step) begin
            unique case (state_q)
                COMP_RED:   state_d = COMP_GREEN;
                COMP_GREEN: state_d = COMP_BLUE;
                COMP_BLUE:  state_d = COMP_RED;
                default:    state_d = COMP_RED;
            endcase
        end
    end

    always_comb begin
        comp = state_q;
        wrap = step && !clear && (state_q == COMP_BLUE);
    end

    // R3
    comp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> state_q == COMP_RED);

    // R5
    comp_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && state_q == COMP_BLUE) |=> state_q == COMP_RED);
endmodule

// File: rtl/gamma_ramp_table.sv
module gamma_ramp_table #(
    parameter int DEPTH = 256,
    parameter int CW    = 10,
    localparam int AW   = $clog2(DEPTH),
    localparam int EW   = 3 * CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [2:0]    ch_we,
    input  logic [EW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [EW-1:0] rdata
);
    logic [EW-1:0] rd_vec [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        localparam logic [CW-1:0] INIT = CW'((e * ((1 << CW) - 1)) / (DEPTH - 1));
        logic [EW-1:0] ent_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= {INIT, INIT, INIT};
            end else if (we && waddr == AW'(e)) begin
                for (int c = 0; c < 3; c++) begin
                    if (ch_we[c]) ent_q[c*CW +: CW] <= wdata[c*CW +: CW];
                end
            end
        end
        assign rd_vec[e] = ent_q;
    end

    assign rdata = rd_vec[raddr];
endmodule

// File: rtl/gamma_pwl_table.sv
module gamma_pwl_table #(
    parameter int DEPTH = 128,
    parameter int FW    = 16,
    parameter int LZ    = 6,
    parameter int DELTA_INIT = 'h200,
    localparam int AW   = $clog2(DEPTH),
    localparam int NSLOT = DEPTH * 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [1:0]    wcomp,
    input  logic [FW-1:0] wbase,
    input  logic [FW-1:0] wdelta,
    input  logic [AW-1:0] raddr,
    input  logic [1:0]    rcomp,
    output logic [FW-1:0] rbase,
    output logic [FW-1:0] rdelta
);
    localparam logic [FW-1:0] LMASK = ~FW'((1 << LZ) - 1);

    logic [2*FW-1:0] rd_vec [NSLOT];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        localparam logic [FW-1:0] BASE0  = FW'((e * ((1 << FW) - 1)) / (DEPTH - 1)) & LMASK;
        localparam logic [FW-1:0] DELTA0 = (e < DEPTH - 1) ? FW'(DELTA_INIT) : '0;
        for (genvar c = 0; c < 3; c++) begin : g_ch
            logic [FW-1:0] base_q, delta_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    base_q  <= BASE0;
                    delta_q <= DELTA0;
                end else if (we && waddr == AW'(e) && wcomp == 2'(c)) begin
                    base_q  <= wbase & LMASK;
                    delta_q <= wdelta & LMASK;
                end
            end
            assign rd_vec[e*3+c] = {delta_q, base_q};
        end
    end

    always_comb begin
        rbase  = '0;
        rdelta = '0;
        if (rcomp != 2'd3) begin
            {rdelta, rbase} = rd_vec[int'(raddr) * 3 + int'(rcomp)];
        end
    end
endmodule

// File: rtl/gamma_lut_port.sv
module gamma_lut_port
    import gamma_lut_pkg::*;
#(
    parameter int RAMP_DEPTH = 256,
    localparam int IDX_W     = $clog2(RAMP_DEPTH),
    localparam int PWL_DEPTH = RAMP_DEPTH / 2,
    localparam int PWL_AW    = IDX_W - 1,
    localparam int EW        = 3 * CH_W,
    localparam int SEQ_LSB   = PWL_FW - CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic [IDX_W-1:0]  ramp_rd_addr,
    output logic [EW-1:0]     ramp_rd_data,
    input  logic [PWL_AW-1:0] pwl_rd_entry,
    input  logic [1:0]        pwl_rd_comp,
    output logic [PWL_FW-1:0] pwl_rd_base,
    output logic [PWL_FW-1:0] pwl_rd_delta,
    output logic [IDX_W-1:0]  cur_index,
    output logic [1:0]        cur_comp,
    output logic              cur_mode,
    output logic              table_changed
);
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             mode_q;
    logic [2:0]       mask_q;
    logic             changed_q;

    logic is_idx, seq_ok, pk_ok, pwl_ok, comp_en;
    logic step, clear, wrap;
    comp_e comp;

    logic             ramp_we, pwl_we;
    logic [2:0]       ramp_ch_we;
    logic [EW-1:0]    ramp_wdata;
    logic [CH_W-1:0]  seq_ch;

    gamma_comp_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .clear (clear),
        .comp  (comp),
        .wrap  (wrap)
    );

    // decode of the host write
    always_comb begin
        is_idx = wr_en && (wr_sel == SEL_INDEX);
        seq_ok = wr_en && (wr_sel == SEL_SEQ)    && !mode_q;
        pk_ok  = wr_en && (wr_sel == SEL_PACKED) && !mode_q;
        pwl_ok = wr_en && (wr_sel == SEL_PWL)    &&  mode_q;
        unique case (comp)
            COMP_RED:   comp_en = mask_q[2];
            COMP_GREEN: comp_en = mask_q[1];
            COMP_BLUE:  comp_en = mask_q[0];
            default:    comp_en = 1'b0;
        endcase
        step  = seq_ok || pwl_ok;
        clear = is_idx || pk_ok;
    end

    // table write controls
    always_comb begin
        seq_ch     = wr_data[SEQ_LSB +: CH_W];
        ramp_ch_we = '0;
        ramp_wdata = wr_data[EW-1:0];
        if (seq_ok) begin
            ramp_wdata = {seq_ch, seq_ch, seq_ch};
            unique case (comp)
                COMP_RED:   ramp_ch_we = {comp_en, 2'b00};
                COMP_GREEN: ramp_ch_we = {1'b0, comp_en, 1'b0};
                COMP_BLUE:  ramp_ch_we = {2'b00, comp_en};
                default:    ramp_ch_we = '0;
            endcase
        end else if (pk_ok) begin
            ramp_ch_we = mask_q;
        end
        ramp_we = |ramp_ch_we;
        pwl_we  = pwl_ok && comp_en;
    end

    // next pointer
    always_comb begin
        idx_d = idx_q;
        if (is_idx) begin
            idx_d = wr_data[IDX_W-1:0];
        end else if (pk_ok || (seq_ok && wrap)) begin
            idx_d = idx_q + 1'b1;
        end else if (pwl_ok && wrap) begin
            idx_d = {idx_q[IDX_W-1], idx_q[PWL_AW-1:0] + 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            mode_q    <= 1'b0;
            mask_q    <= 3'b111;
            changed_q <= 1'b0;
        end else begin
            idx_q     <= idx_d;
            changed_q <= ramp_we || pwl_we;
            if (wr_en && wr_sel == SEL_MODE) mode_q <= wr_data[0];
            if (wr_en && wr_sel == SEL_MASK) mask_q <= wr_data[2:0];
        end
    end

    gamma_ramp_table #(.DEPTH(RAMP_DEPTH), .CW(CH_W)) u_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ramp_we),
        .waddr (idx_q),
        .ch_we (ramp_ch_we),
        .wdata (ramp_wdata),
        .raddr (ramp_rd_addr),
        .rdata (ramp_rd_data)
    );

    gamma_pwl_table #(.DEPTH(PWL_DEPTH), .FW(PWL_FW), .LZ(PWL_LZ)) u_pwl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (pwl_we),
        .waddr  (idx_q[PWL_AW-1:0]),
        .wcomp  (comp),
        .wbase  (wr_data[PWL_FW-1:0]),
        .wdelta (wr_data[2*PWL_FW-1:PWL_FW]),
        .raddr  (pwl_rd_entry),
        .rcomp  (pwl_rd_comp),
        .rbase  (pwl_rd_base),
        .rdelta (pwl_rd_delta)
    );

    always_comb begin
        cur_index     = idx_q;
        cur_comp      = comp;
        cur_mode      = mode_q;
        table_changed = changed_q;
    end

    // R3
    index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_INDEX) |=> (cur_index == $past(wr_data[IDX_W-1:0]) && cur_comp == 2'd0));

    // R7
    pwl_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_PWL && mode_q) |=> cur_index[IDX_W-1] == $past(cur_index[IDX_W-1]));

    // R8
    packed_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_PACKED && !mode_q) |=> (cur_index == $past(cur_index) + 1'b1 && cur_comp == 2'd0));

    // R9
    wrong_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((wr_sel == SEL_PWL && !mode_q) || ((wr_sel == SEL_SEQ || wr_sel == SEL_PACKED) && mode_q)))
        |=> (cur_index == $past(cur_index) && cur_comp == $past(cur_comp) && !table_changed));

    // R10
    change_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        table_changed |-> $past(wr_en));
endmodule

// File: tb/test_gamma_lut_port.sv
module test_gamma_lut_port;
    localparam int DEPTH = 256;
    localparam int PD    = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  ramp_rd_addr = '0;
    logic [29:0] ramp_rd_data;
    logic [6:0]  pwl_rd_entry = '0;
    logic [1:0]  pwl_rd_comp = '0;
    logic [15:0] pwl_rd_base, pwl_rd_delta;
    logic [7:0]  cur_index;
    logic [1:0]  cur_comp;
    logic        cur_mode, table_changed;

    always #4 clk = ~clk;

    gamma_lut_port i_gamma_lut_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ramp_rd_addr(ramp_rd_addr), .ramp_rd_data(ramp_rd_data),
        .pwl_rd_entry(pwl_rd_entry), .pwl_rd_comp(pwl_rd_comp),
        .pwl_rd_base(pwl_rd_base), .pwl_rd_delta(pwl_rd_delta),
        .cur_index(cur_index), .cur_comp(cur_comp), .cur_mode(cur_mode),
        .table_changed(table_changed)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic [29:0] m_ramp  [DEPTH];
    logic [15:0] m_base  [PD][3];
    logic [15:0] m_delta [PD][3];
    logic [7:0]  m_idx;
    int          m_comp;
    bit          m_mode;
    logic [2:0]  m_mask;

    function automatic logic [9:0] ramp_init(int i);
        return 10'((i * 1023) / 255);
    endfunction

    function automatic logic [15:0] base_init(int i);
        return 16'((i * 65535) / 127) & 16'hFFC0;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) m_ramp[i] = {ramp_init(i), ramp_init(i), ramp_init(i)};
        for (int i = 0; i < PD; i++) begin
            for (int c = 0; c < 3; c++) begin
                m_base[i][c]  = base_init(i);
                m_delta[i][c] = (i < PD - 1) ? 16'h0200 : 16'h0000;
            end
        end
        m_idx = '0; m_comp = 0; m_mode = 0; m_mask = 3'b111;
    endtask

    task automatic scan_all(string rtag, string ptag);
        for (int i = 0; i < DEPTH; i++) begin
            ramp_rd_addr = 8'(i);
            #1;
            chk(rtag, $sformatf("ramp[%0d]", i), 32'(ramp_rd_data), 32'(m_ramp[i]));
        end
        for (int i = 0; i < PD; i++) begin
            for (int c = 0; c < 3; c++) begin
                pwl_rd_entry = 7'(i);
                pwl_rd_comp  = 2'(c);
                #1;
                chk(ptag, $sformatf("pwl[%0d][%0d]", i, c),
                    {pwl_rd_delta, pwl_rd_base}, {m_delta[i][c], m_base[i][c]});
            end
        end
    endtask

    // called at a falling edge; returns at the next falling edge after checking
    task automatic do_write(logic [2:0] sel, logic [31:0] data);
        logic [7:0] old_idx;
        int         c;
        bit         en, stored;
        string      tag, itag;
        old_idx = m_idx;
        c       = m_comp;
        en      = m_mask[2 - c];
        stored  = 0;
        tag     = "R11";
        itag    = "R11";
        case (sel)
            3'd0: begin
                tag = "R3"; itag = "R3";
                m_idx = data[7:0]; m_comp = 0;
            end
            3'd1: begin
                if (m_mode) begin tag = "R9"; itag = "R9"; end
                else begin
                    tag = "R4"; itag = "R5";
                    if (en) begin
                        stored = 1;
                        m_ramp[old_idx][(2 - c) * 10 +: 10] = data[15:6];
                    end
                    if (c == 2) begin m_comp = 0; m_idx = old_idx + 8'd1; end
                    else m_comp = c + 1;
                end
            end
            3'd2: begin
                if (m_mode) begin tag = "R9"; itag = "R9"; end
                else begin
                    tag = "R8"; itag = "R8";
                    for (int b = 0; b < 3; b++)
                        if (m_mask[b]) m_ramp[old_idx][b * 10 +: 10] = data[b * 10 +: 10];
                    stored = |m_mask;
                    m_idx  = old_idx + 8'd1;
                    m_comp = 0;
                end
            end
            3'd3: begin
                if (!m_mode) begin tag = "R9"; itag = "R9"; end
                else begin
                    tag = "R6"; itag = "R7";
                    if (en) begin
                        stored = 1;
                        m_base[old_idx[6:0]][c]  = data[15:0] & 16'hFFC0;
                        m_delta[old_idx[6:0]][c] = data[31:16] & 16'hFFC0;
                    end
                    if (c == 2) begin
                        m_comp = 0;
                        m_idx  = {old_idx[7], old_idx[6:0] + 7'd1};
                    end else m_comp = c + 1;
                end
            end
            3'd4: begin tag = "R9"; itag = "R9"; m_mode = data[0]; end
            3'd5: begin m_mask = data[2:0]; end
            default: ;
        endcase
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        chk(itag, "pointer", 32'(cur_index), 32'(m_idx));
        chk(itag, "channel state", 32'(cur_comp), 32'(m_comp));
        chk(tag, "mode", 32'(cur_mode), 32'(m_mode));
        chk("R10", "change pulse", 32'(table_changed), 32'(stored));
        ramp_rd_addr = old_idx;
        pwl_rd_entry = old_idx[6:0];
        pwl_rd_comp  = 2'(c);
        #1;
        chk(tag, "ramp entry", 32'(ramp_rd_data), 32'(m_ramp[old_idx]));
        chk(tag, "pwl slot", {pwl_rd_delta, pwl_rd_base},
            {m_delta[old_idx[6:0]][c], m_base[old_idx[6:0]][c]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3", "reset pointer", 32'(cur_index), 32'd0);
        chk("R3", "reset channel state", 32'(cur_comp), 32'd0);
        chk("R10", "reset pulse", 32'(table_changed), 32'd0);
        chk("R9", "reset mode", 32'(cur_mode), 32'd0);
        scan_all("R1", "R2");
        @(negedge clk);

        // R4 R5: full red/green/blue sequence
        do_write(3'd0, 32'd5);
        do_write(3'd1, 32'h0000_FFC0);
        do_write(3'd1, 32'h0000_1234);
        do_write(3'd1, 32'hFFFF_8001);
        // R4 R11: green masked out by reversed-order mask
        do_write(3'd5, 32'd5);
        do_write(3'd1, 32'h0000_AAC0);
        do_write(3'd1, 32'h0000_5540);
        do_write(3'd1, 32'h0000_3FC0);
        // R10: nothing enabled
        do_write(3'd5, 32'd0);
        do_write(3'd1, 32'h0000_FFFF);
        do_write(3'd2, 32'h3FFF_FFFF);
        // R8 R5: wrap at 255
        do_write(3'd5, 32'd7);
        do_write(3'd0, 32'd255);
        do_write(3'd2, 32'h2345_6789);
        do_write(3'd0, 32'd255);
        do_write(3'd1, 32'h0000_0040);
        do_write(3'd1, 32'h0000_0080);
        do_write(3'd1, 32'h0000_00C0);
        // R3: pointer write mid-sequence
        do_write(3'd1, 32'h0000_1111);
        do_write(3'd0, 32'd9);
        do_write(3'd1, 32'h0000_2222);
        // R9: wrong-mode writes
        do_write(3'd3, 32'hFFFF_FFFF);
        do_write(3'd4, 32'd1);
        do_write(3'd1, 32'h0000_7777);
        do_write(3'd2, 32'h0777_7777);
        // R6 R7: bit 7 kept across pwl wrap
        do_write(3'd0, 32'hFF);
        do_write(3'd3, 32'hFFFF_FFFF);
        do_write(3'd3, 32'h1234_5678);
        do_write(3'd3, 32'h0041_0083);
        do_write(3'd0, 32'h7F);
        do_write(3'd3, 32'h8000_0001);
        do_write(3'd3, 32'h0000_0000);
        do_write(3'd3, 32'hABCD_EF01);
        // R11: unused codes
        do_write(3'd6, 32'hFFFF_FFFF);
        do_write(3'd7, 32'hFFFF_FFFF);
        do_write(3'd4, 32'd0);

        for (int n = 0; n < 3000; n++) begin
            int r;
            logic [2:0] s;
            r = int'($urandom % 16);
            if (r < 6)       s = 3'd1;
            else if (r < 9)  s = 3'd3;
            else if (r < 11) s = 3'd2;
            else if (r < 12) s = 3'd0;
            else if (r < 13) s = 3'd4;
            else if (r < 14) s = 3'd5;
            else             s = 3'(6 + (r & 1));
            do_write(s, $urandom);
        end

        scan_all("R4", "R6");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule